// File: doc/BRIEF.md
# Seeded Random Word Generator Controller

This block is a register-mapped controller for a true random generator. Software writes a command word that either seeds the generator or asks for a batch of random data, 128 or 256 bits wide. It then polls a status word, or waits for an interrupt, and reads up to eight 32-bit result words. While it is seeding or generating the block shows busy flags. When an operation completes it sets a write-one-to-clear event flag. Enable masks and a global gate combine these flags into a single interrupt line.

The block seeds itself once when it leaves reset. It also reseeds on its own after software has drawn a programmable number of 16-byte blocks. A command that arrives while the block is busy, or a generate request that arrives before the first seed has finished, is held in a one-entry slot and runs as soon as it may. In place of the entropy source and conditioner there is a deterministic 32-bit LFSR with fixed latencies, so every result can be predicted.

Top module: `trng_ctrl`

## Requirements
- R1: After reset the block is seeding on its own. The status word at 0x04 reads only bit 31 (reseeding) set, bit 9 (seeded) clear and bit 30 (generating) clear. Event flags at 0x14 read 0 and `irq` is low.
- R2: Offset 0xF0 always reads 0x000046BC. Unmapped offsets read 0.
- R3: Writing command code 2 to offset 0x00 starts a seed. Bit 31 of the status word stays set for exactly SEED_LAT cycles. After that, bit 9 is set and event bit 1 (seed done) is set.
- R4: Writing command code 1 to 0x00 starts a generate. Bit 30 stays set for exactly GEN_LAT_WIDE cycles when mode bit 3 (offset 0x08) is 1, and for GEN_LAT_NARROW cycles when it is 0. After that, event bit 0 (data ready) is set.
- R5: The result words sit at 0x20 + 4·i for i = 0..7. A generate steps the LFSR once per word: word i gets the state after i+1 steps. The LFSR is Galois, shifts right, and folds in taps 0x80200003 when the bit shifted out is 1. A wide generate fills all eight words. A narrow one fills words 0..3 and clears words 4..7.
- R6: The n-th completed seed (counting the one after reset as n = 1) loads the LFSR with 0x12345678 XOR (n × 0x9E3779B9 mod 2^32). A zero result is replaced by 1.
- R7: Writing a 1 to a bit of 0x14 clears that event flag. A 0 leaves it alone. If a flag is set and cleared in the same cycle, the set wins.
- R8: `irq` is high exactly when bit 31 of 0x10 is set and some event flag is set whose enable bit (bit 0 for data ready, bit 1 for seed done) is set.
- R9: A command written while the block is busy is held and runs after the current operation ends. A newer held command replaces an older one. Codes 0 and 3 do nothing.
- R10: With a nonzero count C at 0x60, each generate adds its blocks to a running total (1 for narrow, 2 for wide). When the total reaches C, a reseed starts right after that generate and the total restarts from 0. Any seed resets the total. A count of 0 turns automatic reseeding off.
- R11: A generate never starts while bit 9 is clear. It waits in the held slot until seeding has finished.
- R12: The output size is taken from mode bit 3 when a generate starts. Changing the mode during a generate does not affect that generate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with GEN_LAT_WIDE = 64, GEN_LAT_NARROW = 32 and SEED_LAT = 16. This is short enough to measure every busy window to the exact cycle, while still running dozens of generates and several automatic reseeds. Small reseed counts (1 to 5 blocks) make the auto-reseed threshold trigger many times, for both wide and narrow mixes. Held commands, the write that arrives during the boot seed, and a mode change in the middle of a generate are covered as directed cases. They sit between random generate, seed, flag-clear and interrupt-mask operations, and a bench model predicts every result word.

// File: rtl/trng_pkg.sv
package trng_pkg;

  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 8;

  localparam int OFS_CMD   = 'h00;
  localparam int OFS_STAT  = 'h04;
  localparam int OFS_MODE  = 'h08;
  localparam int OFS_IE    = 'h10;
  localparam int OFS_EVT   = 'h14;
  localparam int OFS_OUT0  = 'h20;
  localparam int OFS_RQ    = 'h60;
  localparam int OFS_VER   = 'hF0;

  localparam int STAT_SEEDED = 9;
  localparam int STAT_GEN    = 30;
  localparam int STAT_RESEED = 31;
  localparam int MODE_WIDE   = 3;
  localparam int IE_GLOBAL   = 31;
  localparam int EV_READY    = 0;
  localparam int EV_SEEDED   = 1;

  localparam logic [WORD_W-1:0] IE_MASK = (WORD_W'(1) << IE_GLOBAL) | WORD_W'(3);

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_GEN  = 2'd1,
    CMD_SEED = 2'd2,
    CMD_RSVD = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SEED = 2'd1,
    PH_GEN  = 2'd2
  } phase_e;

  localparam logic [WORD_W-1:0] LFSR_TAPS   = 32'h8020_0003;
  localparam logic [WORD_W-1:0] SEED_BASE   = 32'h1234_5678;
  localparam logic [WORD_W-1:0] SEED_STRIDE = 32'h9E37_79B9;

  // one right-shifting Galois step
  function automatic logic [WORD_W-1:0] lfsr_next(input logic [WORD_W-1:0] s);
    logic [WORD_W-1:0] n;
    n = s >> 1;
    if (s[0]) n = n ^ LFSR_TAPS;
    return n;
  endfunction

  // seed image from the accumulated stride; zero would lock the LFSR
  function automatic logic [WORD_W-1:0] seed_image(input logic [WORD_W-1:0] acc);
    logic [WORD_W-1:0] v;
    v = SEED_BASE ^ acc;
    return (v == '0) ? WORD_W'(1) : v;
  endfunction

endpackage

// File: rtl/trng_lfsr_bank.sv
module trng_lfsr_bank
  import trng_pkg::*;
#(
  parameter int NWORDS = NUM_WORDS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          seed_fire,
  input  logic                          gen_fire,
  input  logic                          gen_wide,
  output logic [NWORDS-1:0][WORD_W-1:0] out_words
);

  localparam int HALF = NWORDS / 2;

  logic [WORD_W-1:0]            state_q;
  logic [WORD_W-1:0]            stride_q;
  logic [WORD_W-1:0]            stride_next;
  logic [NWORDS:0][WORD_W-1:0]  chain;

  assign chain[0]    = state_q;
  assign stride_next = stride_q + SEED_STRIDE;

  for (genvar g = 0; g < NWORDS; g++) begin : g_chain
    assign chain[g+1] = lfsr_next(chain[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEED_BASE;
      stride_q  <= '0;
      out_words <= '0;
    end else if (seed_fire) begin
      stride_q <= stride_next;
      state_q  <= seed_image(stride_next);
    end else if (gen_fire) begin
      state_q <= gen_wide ? chain[NWORDS] : chain[HALF];
      for (int i = 0; i < NWORDS; i++) begin
        out_words[i] <= (gen_wide || i < HALF) ? chain[i+1] : '0;
      end
    end
  end

endmodule

// File: rtl/trng_seq.sv
module trng_seq
  import trng_pkg::*;
#(
  parameter int GEN_LAT_WIDE   = 1024,
  parameter int GEN_LAT_NARROW = 512,
  parameter int SEED_LAT       = 256,
  parameter int RQ_W           = 16,
  parameter bit BOOT_SEED      = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_wr,
  input  logic [1:0]      cmd_code,
  input  logic            mode_wide,
  input  logic [RQ_W-1:0] rq_limit,
  output logic            seeded,
  output logic            generating,
  output logic            reseeding,
  output logic            gen_start,
  output logic            seed_start,
  output logic            gen_done,
  output logic            seed_done,
  output logic            auto_hit,
  output logic            pend_valid,
  output logic            wide_q
);

  localparam int MAX_LAT = (GEN_LAT_WIDE > GEN_LAT_NARROW)
                         ? ((GEN_LAT_WIDE > SEED_LAT) ? GEN_LAT_WIDE : SEED_LAT)
                         : ((GEN_LAT_NARROW > SEED_LAT) ? GEN_LAT_NARROW : SEED_LAT);
  localparam int CNT_W   = $clog2(MAX_LAT + 1);
  localparam int ACC_W   = RQ_W + 1;

  phase_e              phase_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [ACC_W-1:0]    acc_q;
  logic [ACC_W-1:0]    acc_next;
  logic                seeded_q;
  cmd_e                pend_q;
  logic                pend_q_valid;

  logic                is_idle;
  logic                req_valid;
  logic                sel_valid;
  cmd_e                sel_code;
  logic                start_ok;

  function automatic logic [CNT_W-1:0] lat_load(input int lat);
    return CNT_W'(lat - 1);
  endfunction

  assign is_idle   = (phase_q == PH_IDLE);
  assign req_valid = cmd_wr && (cmd_code == CMD_GEN || cmd_code == CMD_SEED);
  assign sel_valid = req_valid || pend_q_valid;
  assign sel_code  = req_valid ? cmd_e'(cmd_code) : pend_q;
  assign start_ok  = is_idle && sel_valid && (sel_code == CMD_SEED || seeded_q);

  assign gen_done  = (phase_q == PH_GEN)  && (cnt_q == '0);
  assign seed_done = (phase_q == PH_SEED) && (cnt_q == '0);
  assign acc_next  = acc_q + (wide_q ? ACC_W'(2) : ACC_W'(1));
  assign auto_hit  = gen_done && (rq_limit != '0) && (acc_next >= ACC_W'(rq_limit));

  assign gen_start  = start_ok && (sel_code == CMD_GEN);
  assign seed_start = (start_ok && (sel_code == CMD_SEED)) || auto_hit;

  assign seeded     = seeded_q;
  assign generating = (phase_q == PH_GEN);
  assign reseeding  = (phase_q == PH_SEED);
  assign pend_valid = pend_q_valid;

  // phase, latency counter and block total
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= BOOT_SEED ? PH_SEED : PH_IDLE;
      cnt_q    <= BOOT_SEED ? lat_load(SEED_LAT) : '0;
      acc_q    <= '0;
      seeded_q <= 1'b0;
      wide_q   <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_GEN: begin
          if (cnt_q == '0) begin
            if (auto_hit) begin
              phase_q <= PH_SEED;
              cnt_q   <= lat_load(SEED_LAT);
              acc_q   <= '0;
            end else begin
              phase_q <= PH_IDLE;
              acc_q   <= acc_next;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_SEED: begin
          if (cnt_q == '0) begin
            phase_q  <= PH_IDLE;
            seeded_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: begin
          if (gen_start) begin
            phase_q <= PH_GEN;
            wide_q  <= mode_wide;
            cnt_q   <= mode_wide ? lat_load(GEN_LAT_WIDE) : lat_load(GEN_LAT_NARROW);
          end else if (seed_start) begin
            phase_q <= PH_SEED;
            cnt_q   <= lat_load(SEED_LAT);
            acc_q   <= '0;
          end
        end
      endcase
    end
  end

  // one-entry held command slot, newest wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q_valid <= 1'b0;
      pend_q       <= CMD_NOP;
    end else if (req_valid && !start_ok) begin
      pend_q_valid <= 1'b1;
      pend_q       <= cmd_e'(cmd_code);
    end else if (start_ok && !req_valid) begin
      pend_q_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/trng_csr.sv
module trng_csr
  import trng_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NWORDS  = NUM_WORDS,
  parameter int RQ_W    = 16,
  parameter logic [WORD_W-1:0] VERSION = 32'h0000_46BC
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [WORD_W-1:0]             wdata,
  input  logic                          seeded,
  input  logic                          generating,
  input  logic                          reseeding,
  input  logic                          gen_done,
  input  logic                          seed_done,
  input  logic [NWORDS-1:0][WORD_W-1:0] out_words,
  output logic [WORD_W-1:0]             rdata,
  output logic                          irq,
  output logic                          cmd_wr,
  output logic [1:0]                    cmd_code,
  output logic                          mode_wide,
  output logic [RQ_W-1:0]               rq_limit,
  output logic [WORD_W-1:0]             ie,
  output logic [1:0]                    evt
);

  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  logic              hit_mode, hit_ie, hit_evt, hit_rq;
  logic [1:0]        evt_set, evt_clr;
  logic [ADDR_W-1:0] rel;
  logic              word_hit;

  function automatic logic at(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign cmd_wr   = we && at(addr, OFS_CMD);
  assign cmd_code = wdata[1:0];
  assign hit_mode = we && at(addr, OFS_MODE);
  assign hit_ie   = we && at(addr, OFS_IE);
  assign hit_evt  = we && at(addr, OFS_EVT);
  assign hit_rq   = we && at(addr, OFS_RQ);

  assign evt_set = {seed_done, gen_done};
  assign evt_clr = hit_evt ? wdata[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_wide <= 1'b0;
      ie        <= '0;
      rq_limit  <= '0;
      evt       <= '0;
    end else begin
      if (hit_mode) mode_wide <= wdata[MODE_WIDE];
      if (hit_ie)   ie        <= wdata & IE_MASK;
      if (hit_rq)   rq_limit  <= wdata[RQ_W-1:0];
      evt <= evt_set | (evt & ~evt_clr);
    end
  end

  assign irq = ie[IE_GLOBAL] & |(evt & ie[1:0]);

  assign rel      = addr - ADDR_W'(OFS_OUT0);
  assign word_hit = (addr >= ADDR_W'(OFS_OUT0)) && (rel < ADDR_W'(NWORDS * 4)) && (rel[1:0] == 2'b00);

  always_comb begin
    rdata = '0;
    if (word_hit) begin
      rdata = out_words[rel[IDX_W+1:2]];
    end else if (at(addr, OFS_STAT)) begin
      rdata[STAT_SEEDED] = seeded;
      rdata[STAT_GEN]    = generating;
      rdata[STAT_RESEED] = reseeding;
    end else if (at(addr, OFS_MODE)) begin
      rdata[MODE_WIDE] = mode_wide;
    end else if (at(addr, OFS_IE)) begin
      rdata = ie;
    end else if (at(addr, OFS_EVT)) begin
      rdata[1:0] = evt;
    end else if (at(addr, OFS_RQ)) begin
      rdata[RQ_W-1:0] = rq_limit;
    end else if (at(addr, OFS_VER)) begin
      rdata = VERSION;
    end
  end

endmodule

// File: rtl/trng_ctrl.sv
module trng_ctrl
  import trng_pkg::*;
#(
  parameter int ADDR_W         = 8,
  parameter int GEN_LAT_WIDE   = 1024,
  parameter int GEN_LAT_NARROW = 512,
  parameter int SEED_LAT       = 256,
  parameter int RQ_W           = 16,
  parameter bit BOOT_SEED      = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);

  // internal events, named for the bound checker
  logic                             cmd_wr;
  logic [1:0]                       cmd_code;
  logic                             mode_wide;
  logic [RQ_W-1:0]                  rq_limit;
  logic [WORD_W-1:0]                ie;
  logic [1:0]                       evt;
  logic                             st_seeded, st_generating, st_reseeding;
  logic                             gen_start, seed_start, gen_done, seed_done;
  logic                             auto_hit, pend_valid, wide_q;
  logic [NUM_WORDS-1:0][WORD_W-1:0] out_words;

  trng_seq #(
    .GEN_LAT_WIDE   (GEN_LAT_WIDE),
    .GEN_LAT_NARROW (GEN_LAT_NARROW),
    .SEED_LAT       (SEED_LAT),
    .RQ_W           (RQ_W),
    .BOOT_SEED      (BOOT_SEED)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .cmd_code   (cmd_code),
    .mode_wide  (mode_wide),
    .rq_limit   (rq_limit),
    .seeded     (st_seeded),
    .generating (st_generating),
    .reseeding  (st_reseeding),
    .gen_start  (gen_start),
    .seed_start (seed_start),
    .gen_done   (gen_done),
    .seed_done  (seed_done),
    .auto_hit   (auto_hit),
    .pend_valid (pend_valid),
    .wide_q     (wide_q)
  );

  trng_lfsr_bank #(
    .NWORDS (NUM_WORDS)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed_fire (seed_done),
    .gen_fire  (gen_done),
    .gen_wide  (wide_q),
    .out_words (out_words)
  );

  trng_csr #(
    .ADDR_W (ADDR_W),
    .NWORDS (NUM_WORDS),
    .RQ_W   (RQ_W)
  ) u_csr (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .seeded     (st_seeded),
    .generating (st_generating),
    .reseeding  (st_reseeding),
    .gen_done   (gen_done),
    .seed_done  (seed_done),
    .out_words  (out_words),
    .rdata      (reg_rdata),
    .irq        (irq),
    .cmd_wr     (cmd_wr),
    .cmd_code   (cmd_code),
    .mode_wide  (mode_wide),
    .rq_limit   (rq_limit),
    .ie         (ie),
    .evt        (evt)
  );

endmodule

// File: rtl/trng_ctrl_chk.sv
module trng_ctrl_chk #(
  parameter int ADDR_W       = 8,
  parameter int GEN_LAT_WIDE = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              wdata_b0,
  input logic              irq,
  input logic              ie_global,
  input logic [1:0]        evt,
  input logic              seeded,
  input logic              generating,
  input logic              reseeding,
  input logic              gen_start,
  input logic              gen_done,
  input logic              seed_done,
  input logic              auto_hit,
  input logic              pend_valid
);

  localparam int RUN_W = $clog2(GEN_LAT_WIDE + 2);

  logic [RUN_W-1:0] gen_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gen_run <= '0;
    else if (generating) gen_run <= gen_run + 1'b1;
    else                 gen_run <= '0;
  end

  p_gen_needs_seed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    gen_start |-> seeded);

  p_ready_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gen_done |=> evt[0]);

  p_gen_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gen_run <= RUN_W'(GEN_LAT_WIDE));

  p_seed_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seed_done |=> (seeded && evt[1]));

  p_w1c_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'('h14) && wdata_b0 && !gen_done) |=> !evt[0]);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie_global && evt != 2'b00));

  p_auto_reseed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    auto_hit |=> reseeding);

  p_held_runs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && !generating && !reseeding && seeded) |=> (generating || reseeding));

endmodule

bind trng_ctrl trng_ctrl_chk #(
  .ADDR_W       (ADDR_W),
  .GEN_LAT_WIDE (GEN_LAT_WIDE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .wdata_b0   (reg_wdata[0]),
  .irq        (irq),
  .ie_global  (ie[31]),
  .evt        (evt),
  .seeded     (st_seeded),
  .generating (st_generating),
  .reseeding  (st_reseeding),
  .gen_start  (gen_start),
  .gen_done   (gen_done),
  .seed_done  (seed_done),
  .auto_hit   (auto_hit),
  .pend_valid (pend_valid)
);

// File: tb/sim_trng_ctrl.sv
`timescale 1ns/1ps
module sim_trng_ctrl;

  localparam int LW = 64;
  localparam int LN = 32;
  localparam int LS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  trng_ctrl #(
    .ADDR_W(8), .GEN_LAT_WIDE(LW), .GEN_LAT_NARROW(LN), .SEED_LAT(LS), .RQ_W(16), .BOOT_SEED(1'b1)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // ---------------- bench model ----------------
  logic [31:0] m_lfsr = 32'h1234_5678;
  int          m_nseed = 0;
  int          m_acc = 0;
  int          m_rq = 0;
  logic [31:0] m_words [8];
  logic [1:0]  m_evt = 2'b00;
  logic [31:0] m_ie = '0;

  function automatic logic [31:0] b_step(input logic [31:0] s);
    logic [31:0] t = 32'h8020_0003;
    logic [31:0] n;
    for (int i = 0; i < 31; i++) n[i] = s[i+1] ^ (s[0] & t[i]);
    n[31] = s[0] & t[31];
    return n;
  endfunction

  function automatic logic [31:0] b_seed(input int n);
    logic [31:0] prod = 32'(n) * 32'h9E37_79B9;
    logic [31:0] v = 32'h1234_5678 ^ prod;
    return (v == 0) ? 32'd1 : v;
  endfunction

  task automatic m_seed();
    m_nseed++;
    m_lfsr = b_seed(m_nseed);
    m_acc = 0;
    m_evt[1] = 1'b1;
  endtask

  task automatic m_gen(input bit wide);
    for (int i = 0; i < 8; i++) begin
      if (wide || i < 4) begin
        m_lfsr = b_step(m_lfsr);
        m_words[i] = m_lfsr;
      end else begin
        m_words[i] = '0;
      end
    end
    m_evt[0] = 1'b1;
    m_acc += wide ? 2 : 1;
    if (m_rq != 0 && m_acc >= m_rq) m_seed();
  endtask

  // ---------------- access tasks ----------------
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    bit done = 0;
    while (!done) begin
      rd(8'h04, s);
      if (s[31:30] == 2'b00) begin
        @(negedge clk);
        rd(8'h04, s);
        if (s[31:30] == 2'b00) done = 1;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  task automatic check_state(input string req);
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      rd(8'(8'h20 + 4 * i), d);
      check(req, d, m_words[i]);
    end
    rd(8'h14, d);
    check(req, d, {30'd0, m_evt});
    check(req, {31'd0, irq}, {31'd0, m_ie[31] & |(m_evt & m_ie[1:0])});
  endtask

  task automatic measure(input int bitpos, output int cnt);
    logic [31:0] s;
    cnt = 0;
    rd(8'h04, s);
    while (s[bitpos]) begin
      cnt++;
      @(negedge clk);
      rd(8'h04, s);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] d;
    int cnt;
    for (int i = 0; i < 8; i++) m_words[i] = '0;
    void'($urandom(32'd1234));

    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: boot-time seeding visible, nothing else
    rd(8'h04, d); check("R1 status", d, 32'h8000_0000);
    rd(8'h14, d); check("R1 events", d, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'd0);

    // R11: generate issued during boot seed waits for it
    wr(8'h00, 32'd1);
    wait_idle();
    m_seed(); m_gen(1'b0);
    rd(8'h04, d); check("R11 seeded", d, 32'h0000_0200);
    check_state("R11 gen after boot seed");

    // R2: version and unmapped
    rd(8'hF0, d); check("R2 version", d, 32'h0000_46BC);
    rd(8'hC4, d); check("R2 unmapped", d, 32'h0);

    // R7: W1C behaviour
    wr(8'h14, 32'h1); m_evt[0] = 1'b0;
    rd(8'h14, d); check("R7 clear ready only", d, {30'd0, m_evt});
    wr(8'h14, 32'h0);
    rd(8'h14, d); check("R7 zero write no effect", d, {30'd0, m_evt});
    wr(8'h14, 32'h2); m_evt[1] = 1'b0;
    rd(8'h14, d); check("R7 clear seed", d, 32'h0);

    // R4: exact generate windows, wide and narrow
    wr(8'h08, 32'h8);
    rd(8'h08, d); check("R4 mode readback", d, 32'h8);
    wr(8'h00, 32'd1);
    measure(30, cnt); check("R4 wide latency", 32'(cnt), 32'(LW));
    m_gen(1'b1);
    check_state("R5 wide words");
    wr(8'h08, 32'h0);
    wr(8'h00, 32'd1);
    measure(30, cnt); check("R4 narrow latency", 32'(cnt), 32'(LN));
    m_gen(1'b0);
    check_state("R5 narrow words upper zero");

    // R3: exact seed window
    wr(8'h14, 32'h3); m_evt = 2'b00;
    wr(8'h00, 32'd2);
    measure(31, cnt); check("R3 seed latency", 32'(cnt), 32'(LS));
    m_seed();
    check_state("R3 seed done flag");
    wr(8'h00, 32'd1); wait_idle(); m_gen(1'b0);
    check_state("R6 reload after commanded seed");

    // R8: interrupt gating
    wr(8'h14, 32'h2); m_evt[1] = 1'b0;
    wr(8'h10, 32'h1); m_ie = 32'h1;
    check("R8 no global", {31'd0, irq}, 32'd0);
    wr(8'h10, 32'h8000_0001); m_ie = 32'h8000_0001;
    check("R8 ready enabled", {31'd0, irq}, 32'd1);
    wr(8'h10, 32'h8000_0002); m_ie = 32'h8000_0002;
    check("R8 seed only enabled", {31'd0, irq}, 32'd0);
    wr(8'h10, 32'hFFFF_FFFF); m_ie = 32'h8000_0003;
    rd(8'h10, d); check("R8 enable mask", d, 32'h8000_0003);

    // R12: mode change mid-generate
    wr(8'h14, 32'h3); m_evt = 2'b00;
    wr(8'h08, 32'h8);
    wr(8'h00, 32'd1);
    wr(8'h08, 32'h0);
    wait_idle(); m_gen(1'b1);
    check_state("R12 wide kept");

    // R9: held commands, newest wins; reserved codes ignored
    wr(8'h14, 32'h3); m_evt = 2'b00;
    wr(8'h00, 32'd1);
    wr(8'h00, 32'd2);
    wr(8'h00, 32'd1);
    wait_idle(); m_gen(1'b0); m_gen(1'b0);
    check_state("R9 held gen replaced seed");
    wr(8'h00, 32'd3);
    rd(8'h04, d); check("R9 code3 no-op", d, 32'h0000_0200);
    wr(8'h00, 32'd0);
    rd(8'h04, d); check("R9 code0 no-op", d, 32'h0000_0200);
    check_state("R9 nothing changed");

    // R10: auto reseed after 3 narrow blocks, disabled with 0
    wr(8'h60, 32'd3); m_rq = 3; m_acc = 0;
    wr(8'h00, 32'd2); wait_idle(); m_seed();
    wr(8'h14, 32'h3); m_evt = 2'b00;
    for (int k = 0; k < 3; k++) begin
      wr(8'h00, 32'd1); wait_idle(); m_gen(1'b0);
    end
    check_state("R10 auto reseed flagged");
    wr(8'h00, 32'd1); wait_idle(); m_gen(1'b0);
    check_state("R10 data from new seed");
    wr(8'h60, 32'd0); m_rq = 0;
    wr(8'h14, 32'h3); m_evt = 2'b00;
    for (int k = 0; k < 4; k++) begin
      wr(8'h00, 32'd1); wait_idle(); m_gen(1'b0);
    end
    check_state("R10 disabled");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int op = $urandom_range(0, 99);
      if (op < 10) begin
        int r = $urandom_range(0, 5);
        wr(8'h60, 32'(r)); m_rq = r;
      end else if (op < 20) begin
        logic [31:0] v = $urandom();
        wr(8'h14, v); m_evt = m_evt & ~v[1:0];
      end else if (op < 30) begin
        logic [31:0] v = $urandom();
        wr(8'h10, v); m_ie = v & 32'h8000_0003;
      end else if (op < 40) begin
        wr(8'h00, 32'd2); wait_idle(); m_seed();
      end else begin
        bit w = 1'($urandom_range(0, 1));
        wr(8'h08, w ? 32'h8 : 32'h0);
        wr(8'h00, 32'd1); wait_idle(); m_gen(w);
      end
      check_state("R5 R10 random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule